// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port. It has a transmitter that turns bytes into framed serial bits on `txd` and a receiver that rebuilds bytes from `rxd`. Bit timing comes from an external strobe, `os_tick`, which pulses for one clock sixteen times per bit period. The line idles high. Each character starts with one low start bit and is sent least significant bit first. An optional parity bit follows the data, and then one or two high stop bits.

Four plain configuration pins set the frame shape: the format, the stop-bit count, whether parity is computed, and the parity sense. A command strobe (`cmd_we`) carries single-cycle actions: turn the receiver on, or clear one sticky error flag. Each flag has its own clear bit. Characters move in and out through valid/ready handshakes:

- **Transmit side.** A byte is taken when `tx_valid` and `tx_ready` are both high at a clock edge. `tx_ready` is high exactly when the one-entry transmit buffer is empty.
- **Receive side.** `rx_valid` rises when a character completes. The character is consumed when `rx_valid` and `rx_ready` are both high at an edge. Until then, `rx_valid` and `rx_data` hold steady, so the receiver never applies back-pressure to the line. A character that completes while the previous one is still unread is dropped, and the overrun flag is set.

Top module: `uart_xcvr`

## Requirements
- R1: After reset, `txd` is 1, `tx_ready` is 1, `rx_valid` is 0, all three error flags are 0, and the receiver is off.
- R2: A transmitted character is a 0 start bit, then the data bits LSB first, then any parity bit, then the stop bits. Every bit lasts 16 `os_tick` pulses, and `txd` changes only on a tick.
- R3: `cfg_mode` selects the format: 0 = 8 data bits with no parity slot, 1 = 8 data bits plus a parity slot, 2 = 7 data bits plus a parity slot (3 behaves as 0). In format 2 only bits 6:0 are sent, and a received character shows bit 7 as 0.
- R4: When `cfg_par_en` is 1 in a format with a parity slot, the parity bit makes the count of ones over the data and parity bits even (`cfg_par_odd`=0) or odd (`cfg_par_odd`=1). A received parity mismatch sets `err_parity`.
- R5: When `cfg_par_en` is 0, the parity slot is still present in formats 1 and 2, but it is sent as 0 and not checked on receive.
- R6: `cfg_two_stop`=1 gives two stop bits and `cfg_two_stop`=0 gives one. On a back-to-back second character, the slot after the first stop bit is high in the first case and is the next start bit in the second. The receiver checks every stop bit.
- R7: The receiver ignores the line until a command with `cmd_rx_enable`=1 is written.
- R8: A falling edge on `rxd` starts a character only if the line is still low 8 ticks later. A shorter low pulse produces no character and no error.
- R9: A low stop bit sets `err_frame`. All error flags are sticky, and each is cleared only by its own clear bit (`cmd_clr_frame`, `cmd_clr_parity`, `cmd_clr_overrun`) with `cmd_we`=1.
- R10: If a character completes while `rx_valid` is 1 and no read happens that cycle, `err_overrun` is set and `rx_data` keeps the earlier character.
- R11: After a byte is accepted, `tx_ready` is 0 until the buffer moves into the shifter. `rx_valid` falls when the host reads with `rx_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| os_tick | input | 1 | Oversampling strobe, 16 per bit |
| cfg_mode | input | 2 | Frame format (0: 8 bits, 1: 8 bits+parity, 2: 7 bits+parity) |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_par_en | input | 1 | Compute and check parity |
| cfg_par_odd | input | 1 | 1 odd parity, 0 even parity |
| cmd_we | input | 1 | Command strobe |
| cmd_rx_enable | input | 1 | Turn the receiver on |
| cmd_clr_frame | input | 1 | Clear the framing error flag |
| cmd_clr_parity | input | 1 | Clear the parity error flag |
| cmd_clr_overrun | input | 1 | Clear the overrun flag |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmit buffer empty |
| tx_data | input | 8 | Transmit byte |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rx_valid | output | 1 | Received character available |
| rx_ready | input | 1 | Host reads the character |
| rx_data | output | 8 | Received character |
| err_frame | output | 1 | Sticky framing error |
| err_parity | output | 1 | Sticky parity error |
| err_overrun | output | 1 | Sticky overrun |

## Verification
The hardest situation to reach is a character that finishes while an earlier one is still unread. The bench reaches it by keeping `rx_ready` low across two complete serial frames, then checks that the first byte is retained and the overrun flag is raised. A second hard case is a low stop bit that leaves the line low after the character ends: the receiver must not treat this as a new start. The bench drives exactly this pattern, in both the one-stop and two-stop layouts, and then follows it with clean frames. Start-bit glitches are produced by holding `rxd` low for only three ticks.

// File: rtl/uart_pkg.sv
`timescale 1ns/1ps
package uart_pkg;
  typedef enum logic [1:0] {
    FMT_8N  = 2'd0,
    FMT_8P  = 2'd1,
    FMT_7P  = 2'd2,
    FMT_RSV = 2'd3
  } fmt_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_START, PH_DATA, PH_PAR, PH_STOP
  } phase_e;

  function automatic logic fmt_has_par(input fmt_e m);
    return (m == FMT_8P) || (m == FMT_7P);
  endfunction

  function automatic logic fmt_short(input fmt_e m);
    return (m == FMT_7P);
  endfunction
endpackage

// File: rtl/uart_tx.sv
`timescale 1ns/1ps
module uart_tx import uart_pkg::*; #(
  parameter int OS_RATE = 16,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_two_stop,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              txd
);
  localparam int CW = $clog2(OS_RATE);
  localparam int BW = $clog2(DATA_W);
  localparam logic [CW-1:0] CNT_LAST = CW'(OS_RATE - 1);

  logic              buf_full;
  logic [DATA_W-1:0] buf_q, sh_q;
  phase_e            ph;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bit_idx;
  logic              stop_idx, f_short, f_par, f_two, par_q, txd_q;
  logic              last_stop, launch;
  logic [BW-1:0]     last_idx;
  fmt_e              mode;

  assign mode      = fmt_e'(cfg_mode);
  assign tx_ready  = !buf_full;
  assign txd       = txd_q;
  assign last_idx  = f_short ? BW'(DATA_W - 2) : BW'(DATA_W - 1);
  assign last_stop = (ph == PH_STOP) && (cnt == CNT_LAST) && (!f_two || stop_idx);
  assign launch    = tick && buf_full && ((ph == PH_IDLE) || last_stop);

  function automatic logic calc_par(input logic [DATA_W-1:0] d, input logic short7,
                                    input logic odd);
    logic [DATA_W-1:0] m;
    m = d;
    if (short7) m[DATA_W-1] = 1'b0;
    return (^m) ^ odd;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_full <= 1'b0;
      buf_q    <= '0;
      sh_q     <= '0;
      ph       <= PH_IDLE;
      cnt      <= '0;
      bit_idx  <= '0;
      stop_idx <= 1'b0;
      f_short  <= 1'b0;
      f_par    <= 1'b0;
      f_two    <= 1'b0;
      par_q    <= 1'b0;
      txd_q    <= 1'b1;
    end else begin
      if (tx_valid && !buf_full) begin
        buf_full <= 1'b1;
        buf_q    <= tx_data;
      end
      if (launch) begin
        buf_full <= 1'b0;
        sh_q     <= buf_q;
        f_short  <= fmt_short(mode);
        f_par    <= fmt_has_par(mode);
        f_two    <= cfg_two_stop;
        par_q    <= cfg_par_en ? calc_par(buf_q, fmt_short(mode), cfg_par_odd) : 1'b0;
        ph       <= PH_START;
        cnt      <= '0;
        stop_idx <= 1'b0;
        txd_q    <= 1'b0;
      end else if (tick && ph != PH_IDLE) begin
        if (cnt == CNT_LAST) begin
          cnt <= '0;
          unique case (ph)
            PH_START: begin
              ph      <= PH_DATA;
              bit_idx <= '0;
              txd_q   <= sh_q[0];
              sh_q    <= sh_q >> 1;
            end
            PH_DATA: begin
              if (bit_idx == last_idx) begin
                if (f_par) begin
                  ph    <= PH_PAR;
                  txd_q <= par_q;
                end else begin
                  ph    <= PH_STOP;
                  txd_q <= 1'b1;
                end
              end else begin
                bit_idx <= bit_idx + 1'b1;
                txd_q   <= sh_q[0];
                sh_q    <= sh_q >> 1;
              end
            end
            PH_PAR: begin
              ph    <= PH_STOP;
              txd_q <= 1'b1;
            end
            PH_STOP: begin
              if (f_two && !stop_idx) stop_idx <= 1'b1;
              else                    ph       <= PH_IDLE;
            end
            default: ph <= PH_IDLE;
          endcase
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R11: an accepted byte fills the buffer, so the next cycle is not ready
  a_r11_full_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_ready);
  // R2: the serial line moves only on an oversampling strobe
  a_r2_line_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd) |-> $past(tick));
endmodule

// File: rtl/uart_rx.sv
`timescale 1ns/1ps
module uart_rx import uart_pkg::*; #(
  parameter int OS_RATE = 16,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_two_stop,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              rx_en_set,
  input  logic              clr_fe,
  input  logic              clr_pe,
  input  logic              clr_oe,
  input  logic              rx_ready,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              err_fe,
  output logic              err_pe,
  output logic              err_oe
);
  localparam int CW = $clog2(OS_RATE);
  localparam int BW = $clog2(DATA_W);
  localparam logic [CW-1:0] CNT_LAST = CW'(OS_RATE - 1);
  localparam logic [CW-1:0] CNT_HALF = CW'(OS_RATE / 2 - 1);

  logic [1:0]        sync_q;
  logic              rx_s, rx_s_d, rx_en, fall_pend;
  phase_e            ph;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bit_idx, last_idx;
  logic [DATA_W-1:0] sh_q, word;
  logic              stop_idx, f_short, f_par, f_two, f_pen, f_odd, par_s, fe_acc;
  logic              done_q, frm_fe, frm_pe;
  logic [DATA_W-1:0] frm_data;
  logic              oe_set;
  fmt_e              mode;

  assign mode     = fmt_e'(cfg_mode);
  assign rx_s     = sync_q[1];
  assign last_idx = f_short ? BW'(DATA_W - 2) : BW'(DATA_W - 1);
  assign word     = f_short ? {1'b0, sh_q[DATA_W-1:1]} : sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= 2'b11;
      rx_s_d    <= 1'b1;
      rx_en     <= 1'b0;
      fall_pend <= 1'b0;
      ph        <= PH_IDLE;
      cnt       <= '0;
      bit_idx   <= '0;
      sh_q      <= '0;
      stop_idx  <= 1'b0;
      f_short   <= 1'b0;
      f_par     <= 1'b0;
      f_two     <= 1'b0;
      f_pen     <= 1'b0;
      f_odd     <= 1'b0;
      par_s     <= 1'b0;
      fe_acc    <= 1'b0;
      done_q    <= 1'b0;
      frm_fe    <= 1'b0;
      frm_pe    <= 1'b0;
      frm_data  <= '0;
    end else begin
      sync_q <= {sync_q[0], rxd};
      rx_s_d <= rx_s;
      done_q <= 1'b0;
      if (rx_en_set) rx_en <= 1'b1;
      unique case (ph)
        PH_IDLE: begin
          if (rx_en && rx_s_d && !rx_s) fall_pend <= 1'b1;
          if (tick && fall_pend) begin
            fall_pend <= 1'b0;
            ph        <= PH_START;
            cnt       <= '0;
            f_short   <= fmt_short(mode);
            f_par     <= fmt_has_par(mode);
            f_two     <= cfg_two_stop;
            f_pen     <= cfg_par_en;
            f_odd     <= cfg_par_odd;
            fe_acc    <= 1'b0;
            stop_idx  <= 1'b0;
          end
        end
        PH_START: if (tick) begin
          if (cnt == CNT_HALF) begin
            cnt     <= '0;
            bit_idx <= '0;
            ph      <= rx_s ? PH_IDLE : PH_DATA;
          end else cnt <= cnt + 1'b1;
        end
        PH_DATA: if (tick) begin
          if (cnt == CNT_LAST) begin
            cnt     <= '0;
            sh_q    <= {rx_s, sh_q[DATA_W-1:1]};
            bit_idx <= bit_idx + 1'b1;
            if (bit_idx == last_idx) ph <= f_par ? PH_PAR : PH_STOP;
          end else cnt <= cnt + 1'b1;
        end
        PH_PAR: if (tick) begin
          if (cnt == CNT_LAST) begin
            cnt   <= '0;
            par_s <= rx_s;
            ph    <= PH_STOP;
          end else cnt <= cnt + 1'b1;
        end
        PH_STOP: if (tick) begin
          if (cnt == CNT_LAST) begin
            cnt <= '0;
            if (!rx_s) fe_acc <= 1'b1;
            if (f_two && !stop_idx) begin
              stop_idx <= 1'b1;
            end else begin
              ph       <= PH_IDLE;
              done_q   <= 1'b1;
              frm_data <= word;
              frm_fe   <= fe_acc | !rx_s;
              frm_pe   <= f_par && f_pen && (par_s != ((^word) ^ f_odd));
            end
          end else cnt <= cnt + 1'b1;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign oe_set = done_q && rx_valid && !rx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
      err_fe   <= 1'b0;
      err_pe   <= 1'b0;
      err_oe   <= 1'b0;
    end else begin
      if (done_q && !oe_set) begin
        rx_valid <= 1'b1;
        rx_data  <= frm_data;
      end else if (rx_valid && rx_ready) begin
        rx_valid <= 1'b0;
      end
      err_fe <= (done_q && frm_fe) || (err_fe && !clr_fe);
      err_pe <= (done_q && frm_pe) || (err_pe && !clr_pe);
      err_oe <= oe_set || (err_oe && !clr_oe);
    end
  end

  // R9: each flag survives until its own clear bit
  a_r9_fe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_fe && !clr_fe |=> err_fe);
  a_r4_pe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_pe && !clr_pe |=> err_pe);
  a_r10_oe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_oe && !clr_oe |=> err_oe);
  // R10 / R11: an unread character is held intact
  a_r10_hold_unread: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));
  // R7: no frame activity before the receiver is turned on
  a_r7_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> ph == PH_IDLE);
endmodule

// File: rtl/uart_xcvr.sv
`timescale 1ns/1ps
module uart_xcvr #(
  parameter int OS_RATE = 16,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_two_stop,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cmd_we,
  input  logic              cmd_rx_enable,
  input  logic              cmd_clr_frame,
  input  logic              cmd_clr_parity,
  input  logic              cmd_clr_overrun,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              txd,
  input  logic              rxd,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              err_frame,
  output logic              err_parity,
  output logic              err_overrun
);
  uart_tx #(.OS_RATE(OS_RATE), .DATA_W(DATA_W)) u_tx (
    .clk, .rst_n, .tick(os_tick), .cfg_mode, .cfg_two_stop, .cfg_par_en,
    .cfg_par_odd, .tx_valid, .tx_ready, .tx_data, .txd
  );

  uart_rx #(.OS_RATE(OS_RATE), .DATA_W(DATA_W)) u_rx (
    .clk, .rst_n, .tick(os_tick), .rxd, .cfg_mode, .cfg_two_stop, .cfg_par_en,
    .cfg_par_odd,
    .rx_en_set(cmd_we && cmd_rx_enable),
    .clr_fe(cmd_we && cmd_clr_frame),
    .clr_pe(cmd_we && cmd_clr_parity),
    .clr_oe(cmd_we && cmd_clr_overrun),
    .rx_ready, .rx_valid, .rx_data,
    .err_fe(err_frame), .err_pe(err_parity), .err_oe(err_overrun)
  );
endmodule

// File: tb/uart_xcvr_tb.sv
`timescale 1ns/1ps
module uart_xcvr_tb;
  logic clk = 1'b0, rst_n = 1'b0, os_tick = 1'b0;
  logic [1:0] cfg_mode = 2'd0;
  logic cfg_two_stop = 0, cfg_par_en = 0, cfg_par_odd = 0;
  logic cmd_we = 0, cmd_rx_enable = 0, cmd_clr_frame = 0, cmd_clr_parity = 0, cmd_clr_overrun = 0;
  logic tx_valid = 0, tx_ready, txd, rxd = 1'b1, rx_valid, rx_ready = 0;
  logic [7:0] tx_data = '0, rx_data;
  logic err_frame, err_parity, err_overrun;
  int n_vec = 0, n_fail = 0;
  bit finished = 0;

  uart_xcvr u_dut (.*);

  always #5 clk = ~clk;

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      os_tick = 1'b1;
      @(negedge clk);
      os_tick = 1'b0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      do @(posedge clk); while (!os_tick);
    end
    #1;
  endtask

  function automatic int mk_frame(input logic [7:0] d, input logic [1:0] m, input logic two,
                                  input logic pen, input logic podd, output logic [12:0] f);
    int k;
    int nd;
    logic [7:0] dm;
    f  = '1;
    nd = (m == 2'd2) ? 7 : 8;
    dm = (m == 2'd2) ? (d & 8'h7f) : d;
    f[0] = 1'b0;
    for (int i = 0; i < nd; i++) f[1+i] = d[i];
    k = 1 + nd;
    if (m == 2'd1 || m == 2'd2) begin
      f[k] = pen ? ((^dm) ^ podd) : 1'b0;
      k++;
    end
    f[k] = 1'b1;
    k++;
    if (two) begin
      f[k] = 1'b1;
      k++;
    end
    return k;
  endfunction

  task automatic capture(input int n, output logic [12:0] c);
    c = '1;
    do @(negedge clk); while (txd !== 1'b0);
    wait_ticks(8);
    c[0] = txd;
    for (int i = 1; i < n; i++) begin
      wait_ticks(16);
      c[i] = txd;
    end
  endtask

  task automatic tx_write(input logic [7:0] d);
    do @(negedge clk); while (!tx_ready);
    tx_data  = d;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic send_bits(input logic [12:0] f, input int n);
    for (int i = 0; i < n; i++) begin
      rxd = f[i];
      wait_ticks(16);
    end
    rxd = 1'b1;
    wait_ticks(4);
  endtask

  task automatic command(input logic en, input logic cf, input logic cp, input logic co);
    @(negedge clk);
    cmd_we = 1; cmd_rx_enable = en; cmd_clr_frame = cf; cmd_clr_parity = cp; cmd_clr_overrun = co;
    @(negedge clk);
    cmd_we = 0; cmd_rx_enable = 0; cmd_clr_frame = 0; cmd_clr_parity = 0; cmd_clr_overrun = 0;
  endtask

  task automatic host_read();
    @(negedge clk);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic set_cfg(input logic [1:0] m, input logic two, input logic pen, input logic podd);
    @(negedge clk);
    cfg_mode = m; cfg_two_stop = two; cfg_par_en = pen; cfg_par_odd = podd;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 txd", txd, 1);
    check("R1 tx_ready", tx_ready, 1);
    check("R1 rx_valid", rx_valid, 0);
    check("R1 flags", {err_frame, err_parity, err_overrun}, 0);
  endtask

  task automatic t_tx_frame(input string req, input logic [7:0] d, input logic [1:0] m,
                            input logic pen, input logic podd);
    logic [12:0] e, c;
    int n;
    set_cfg(m, 1'b0, pen, podd);
    n = mk_frame(d, m, 1'b0, pen, podd, e);
    fork
      tx_write(d);
      capture(n, c);
    join
    check(req, c & ((13'd1 << n) - 1), e & ((13'd1 << n) - 1));
    wait_ticks(24);
  endtask

  task automatic t_tx_stop(input logic two);
    logic [12:0] c;
    set_cfg(2'd0, two, 1'b0, 1'b0);
    fork
      begin
        tx_write(8'hF0);
        tx_write(8'h0F);
        @(negedge clk);
        check("R11 tx_ready low while buffer full", tx_ready, 0);
      end
      capture(11, c);
    join
    check("R2 first frame bits", c[9:0], 10'b1111100000);
    check("R6 slot after first stop", c[10], two ? 1 : 0);
    wait_ticks(16 * 14);
  endtask

  task automatic t_rx_off();
    logic [12:0] f;
    int n;
    set_cfg(2'd0, 0, 0, 0);
    n = mk_frame(8'h5A, 2'd0, 0, 0, 0, f);
    send_bits(f, n);
    check("R7 disabled receiver", {rx_valid, err_frame, err_parity}, 0);
  endtask

  task automatic t_rx_good(input string req, input logic [7:0] d, input logic [1:0] m, input logic two,
                           input logic pen, input logic podd, input logic [7:0] exp);
    logic [12:0] f;
    int n;
    set_cfg(m, two, pen, podd);
    n = mk_frame(d, m, two, pen, podd, f);
    send_bits(f, n);
    check({req, " valid"}, rx_valid, 1);
    check({req, " data"}, rx_data, exp);
    check({req, " no errors"}, {err_frame, err_parity, err_overrun}, 0);
    host_read();
    check("R11 read clears rx_valid", rx_valid, 0);
  endtask

  task automatic t_rx_parity_err();
    logic [12:0] f;
    int n;
    set_cfg(2'd1, 0, 1, 0);
    n = mk_frame(8'h96, 2'd1, 0, 1, 0, f);
    f[9] = ~f[9];
    send_bits(f, n);
    check("R4 parity mismatch", err_parity, 1);
    command(0, 1, 0, 0);
    check("R9 frame clear leaves parity flag", err_parity, 1);
    command(0, 0, 1, 0);
    check("R9 parity clear", err_parity, 0);
    host_read();
  endtask

  task automatic t_rx_frame_err(input logic two);
    logic [12:0] f;
    int n;
    set_cfg(2'd0, two, 0, 0);
    n = mk_frame(8'h81, 2'd0, two, 0, 0, f);
    f[n-1] = 1'b0;
    send_bits(f, n);
    check(two ? "R6 second stop low" : "R9 stop low", err_frame, 1);
    command(0, 0, 1, 1);
    check("R9 other clears leave frame flag", err_frame, 1);
    command(0, 1, 0, 0);
    check("R9 frame clear", err_frame, 0);
    host_read();
  endtask

  task automatic t_rx_glitch();
    set_cfg(2'd0, 0, 0, 0);
    rxd = 1'b0;
    wait_ticks(3);
    rxd = 1'b1;
    wait_ticks(200);
    check("R8 glitch ignored", {rx_valid, err_frame}, 0);
  endtask

  task automatic t_rx_overrun();
    logic [12:0] f;
    int n;
    set_cfg(2'd0, 0, 0, 0);
    n = mk_frame(8'h11, 2'd0, 0, 0, 0, f);
    send_bits(f, n);
    n = mk_frame(8'h22, 2'd0, 0, 0, 0, f);
    send_bits(f, n);
    check("R10 overrun flag", err_overrun, 1);
    check("R10 first byte kept", rx_data, 8'h11);
    check("R10 still valid", rx_valid, 1);
    command(0, 0, 0, 1);
    check("R9 overrun clear", err_overrun, 0);
    host_read();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_tx_frame("R2 8-bit frame", 8'hA5, 2'd0, 0, 0);
    t_tx_frame("R3 R4 7-bit odd frame", 8'hC3, 2'd2, 1, 1);
    t_tx_frame("R4 8-bit even frame", 8'h6D, 2'd1, 1, 0);
    t_tx_frame("R5 parity slot forced low", 8'h01, 2'd1, 0, 0);
    t_tx_stop(1'b1);
    t_tx_stop(1'b0);
    t_rx_off();
    command(1, 0, 0, 0);
    t_rx_good("R2 rx 8-bit", 8'h3C, 2'd0, 0, 0, 0, 8'h3C);
    t_rx_good("R3 rx 7-bit msb zero", 8'hD5, 2'd2, 0, 1, 0, 8'h55);
    t_rx_good("R4 rx odd parity", 8'hB2, 2'd1, 0, 1, 1, 8'hB2);
    t_rx_good("R5 rx unchecked parity", 8'h07, 2'd1, 0, 0, 0, 8'h07);
    t_rx_good("R6 rx two stop", 8'h42, 2'd0, 1, 0, 0, 8'h42);
    t_rx_parity_err();
    t_rx_frame_err(1'b0);
    t_rx_frame_err(1'b1);
    t_rx_good("R9 recovery after low stop", 8'h9E, 2'd0, 0, 0, 0, 8'h9E);
    t_rx_glitch();
    t_rx_overrun();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule